// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer Mode

This block keeps eight single-bit values in level-sensitive latches, one per output line. A binary select picks one latch at a time. A single data bit is steered into it. Two active-low controls, a clear and an enable, together choose one of four modes:

- **Write:** the selected latch becomes transparent to the data bit, and the other seven keep their values.
- **Hold:** every latch keeps its value, whatever the data and select inputs do.
- **Demultiplexer:** the selected output copies the data bit and every other output is forced low.
- **Clear:** all outputs go low at once. Clearing needs no clock edge.

The block is used as a small working register that is loaded one bit at a time, as a serial-to-parallel holding register, or as an active-high one-of-eight decoder. The select must only change while the enable is inactive (high). If it changes while the enable is active, a latch that is not the target can capture the data bit.

Top module: `addr_latch8`

## Requirements
- R1: With clear_n high and enable_n low, q_out[addr] follows din transparently, and the other seven outputs keep their previous levels.
- R2: With clear_n high and enable_n high, all eight outputs keep their levels while din and addr change.
- R3: With clear_n low and enable_n low, q_out[addr] equals din and every other output is low.
- R4: With clear_n low and enable_n high, all outputs are low. This takes effect asynchronously, with no clock involved.
- R5: addr is an unsigned binary index with addr[2] as the most significant bit. The value k selects q_out[k], so 3'b000 selects bit 0 and 3'b111 selects bit 7.
- R6: Raising enable_n while din is steady freezes the selected output at that din level. Later changes of din have no effect.
- R7: Moving from clear or demultiplexer mode into hold mode leaves each output at the level it showed just before the change. Outputs that were forced low stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 1 | Data bit steered to the selected latch |
| addr | input | 3 | Latch select, binary, bit 2 is the most significant |
| enable_n | input | 1 | Active-low enable; hold it high while addr changes |
| clear_n | input | 1 | Active-low clear; with enable_n it selects the mode |
| q_out | output | 8 | Parallel latch outputs, one per address |

## Verification
**Walking writes.** Every address is written with both data polarities, one after another, against a reference image of the eight bits. This separates a correct decode from one with swapped or stuck select bits, and it shows that neighbouring latches are left alone.

**Write mode.** Toggling din while a write is open shows transparency. Changing din after enable_n rises shows that the latch closes.

**Hold mode.** Sweeping din and addr through all values in hold mode exposes any leak into the stored bits.

**Demultiplexer and clear modes.** Each address is driven with din at 0 and at 1 in demultiplexer mode, which tests the forced-low override on all eight lines. Clear is applied without waiting for a clock edge, and each mode is then left for hold mode, to show that the levels left behind are kept.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;

  // Map the two active-low controls onto one of the four operating modes.
  function automatic mode_e mode_of(input logic clear_n, input logic enable_n);
    mode_e m;
    case ({clear_n, enable_n})
      2'b10:   m = MODE_WRITE;
      2'b11:   m = MODE_HOLD;
      2'b00:   m = MODE_DEMUX;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alatch_decode.sv
module alatch_decode #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      hit
);
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/alatch_cell.sv
module alatch_cell (
  input  logic load,
  input  logic nxt,
  output logic store
);
  always_latch begin
    if (load) store <= nxt;
  end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enable_n,
  input  logic              clear_n,
  output logic [N-1:0]      q_out
);
  import alatch_pkg::*;

  mode_e        mode;
  logic [N-1:0] hit;
  logic [N-1:0] steer;   // selected and enabled
  logic [N-1:0] load;
  logic [N-1:0] nxt;
  logic [N-1:0] store;

  assign mode = mode_of(clear_n, enable_n);

  alatch_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .hit  (hit)
  );

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign steer[i] = hit[i] & ~enable_n;
    // Clear/demux force unselected cells to zero so levels survive mode exit.
    assign load[i]  = steer[i] | ~clear_n;
    assign nxt[i]   = steer[i] & din;

    alatch_cell u_cell (
      .load  (load[i]),
      .nxt   (nxt[i]),
      .store (store[i])
    );

    // Combinational override of the latch output in clear and demux modes.
    always_comb begin
      case (mode)
        MODE_DEMUX: q_out[i] = hit[i] & din;
        MODE_CLEAR: q_out[i] = 1'b0;
        default:    q_out[i] = store[i];
      endcase
    end
  end
endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input logic              din,
  input logic [ADDR_W-1:0] addr,
  input logic              enable_n,
  input logic              clear_n,
  input logic [N-1:0]      q_out
);
  always_comb begin
    if (!clear_n && enable_n) begin
      // R4
      clear_zero_chk: assert (q_out == '0) else $error("clear mode output not low");
    end
    if (!clear_n && !enable_n) begin
      // R3
      demux_onehot_chk: assert ($onehot0(q_out)) else $error("demux drives more than one line");
      // R3
      demux_follow_chk: assert (q_out[addr] == din) else $error("demux line does not follow data");
    end
    if (clear_n && !enable_n) begin
      // R1
      write_follow_chk: assert (q_out[addr] == din) else $error("open latch does not follow data");
    end
  end
endmodule

bind addr_latch8 addr_latch8_chk #(.ADDR_W(ADDR_W)) u_chk (
  .din      (din),
  .addr     (addr),
  .enable_n (enable_n),
  .clear_n  (clear_n),
  .q_out    (q_out)
);

// File: tb/test_addr_latch8.sv
module test_addr_latch8;
  logic       clk = 1'b0;
  logic       din;
  logic [2:0] addr;
  logic       enable_n;
  logic       clear_n;
  logic [7:0] q_out;
  logic [7:0] model;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_latch8 i_addr_latch8 (
    .din      (din),
    .addr     (addr),
    .enable_n (enable_n),
    .clear_n  (clear_n),
    .q_out    (q_out)
  );

  task automatic settle;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (q_out !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, q_out, exp);
    end
  endtask

  // R1/R5: one write cycle obeying the enable-high-while-addressing rule
  task automatic write_bit(input logic [2:0] a, input logic v);
    enable_n = 1'b1; settle;
    addr = a; settle;
    din = v; settle;
    enable_n = 1'b0; settle;
    model[a] = v;
    check("R1/R5 write", model);
    enable_n = 1'b1; settle;
    check("R1 after close", model);
  endtask

  task automatic t_reset;
    clear_n = 1'b0; enable_n = 1'b1; din = 1'b1; addr = 3'd0;
    model = 8'h00;
    settle;
    check("R4 reset state", model);
    clear_n = 1'b1; settle;
    check("R7 clear to hold", model);
  endtask

  task automatic t_walk;
    for (int a = 0; a < 8; a++) write_bit(3'(a), 1'b1);
    for (int a = 0; a < 8; a++) write_bit(3'(a), 1'b0);
    for (int a = 0; a < 8; a++) write_bit(3'(a), a[0]);
    for (int a = 7; a >= 0; a--) write_bit(3'(a), ~a[1]);
  endtask

  task automatic t_transparent;
    enable_n = 1'b1; settle;
    addr = 3'd5; din = 1'b0; settle;
    enable_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      din = k[0]; settle;
      model[5] = k[0];
      check("R1 transparent", model);
    end
    din = 1'b1; settle; model[5] = 1'b1;
    enable_n = 1'b1; settle;
    din = 1'b0; settle;
    check("R6 freeze", model);
    din = 1'b1; settle; din = 1'b0; settle;
    check("R6 freeze after toggle", model);
  endtask

  task automatic t_hold;
    enable_n = 1'b1; clear_n = 1'b1; settle;
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); din = ~model[a]; settle;
      check("R2 hold", model);
      din = model[a]; settle;
      check("R2 hold", model);
    end
  endtask

  task automatic t_demux;
    clear_n = 1'b0; enable_n = 1'b1; settle;
    check("R4 clear", 8'h00);
    for (int a = 0; a < 8; a++) begin
      for (int v = 0; v < 2; v++) begin
        enable_n = 1'b1; settle;
        addr = 3'(a); settle;
        din = v[0]; settle;
        enable_n = 1'b0; settle;
        check("R3/R5 demux", v[0] ? (8'h01 << a) : 8'h00);
      end
    end
    enable_n = 1'b1; settle;
    addr = 3'd6; settle;
    din = 1'b1; enable_n = 1'b0; settle;
    check("R3 demux line 6", 8'h40);
    clear_n = 1'b1; enable_n = 1'b1; settle;
    model = 8'h40;
    check("R7 demux to hold", model);
    din = 1'b0; addr = 3'd1; settle;
    check("R7 levels kept", model);
  endtask

  task automatic t_async_clear;
    write_bit(3'd0, 1'b1);
    write_bit(3'd3, 1'b1);
    @(posedge clk); #1;
    clear_n = 1'b0;
    #0.5;
    model = 8'h00;
    check("R4 async clear", model);
    #0.5;
    clear_n = 1'b1; settle;
    check("R7 clear to hold", model);
  endtask

  initial begin
    t_reset;
    t_walk;
    t_transparent;
    t_hold;
    t_demux;
    t_async_clear;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule